// File: doc/BRIEF.md
# Histogram ADC Linearity Analyzer

This block measures the static linearity of an analog-to-digital converter by code-density counting. While a slow linear ramp sweeps the converter input, every valid output code increments one bin of an internal occurrence memory. On command, the block walks the retained bins and emits a per-code record holding the count, the differential nonlinearity (DNL), the integral nonlinearity (INL) and a missing-code flag. A one-cycle done strobe follows the last record.

The two over-range bins, the lowest and the full-scale code, are left out of both the average and the output. The average count is never formed as a rounded value. Each DNL value is computed exactly as `count * (2^B - 2) * 2^F / sum - 2^F`, where F is the number of fractional bits. One sequential restoring divider is shared by all codes. A clear command, and also reset, sweeps every bin to zero, one bin per cycle. Samples that arrive while the block is clearing or computing are discarded and counted.

Top module: `adc_lin_histo`

## Requirements
- R1: While the block is idle, each cycle with `smp_valid` high adds one to the bin selected by `smp_code`, and the record for that code reports the accumulated total in `rec_count`.
- R2: A compute emits exactly one record for each code from 1 to 2^B-2, in ascending order. Codes 0 and 2^B-1 never appear in a record and do not contribute to the sum used for DNL.
- R3: `rec_dnl` is a two's-complement value with FRAC_W fractional bits, equal to floor(count * (2^B-2) * 2^FRAC_W / S) - 2^FRAC_W, where S is the sum of the counts of codes 1 to 2^B-2.
- R4: `rec_inl` equals the sum of `rec_dnl` over every record of the current compute, up to and including the present code.
- R5: `rec_missing` is high exactly when DNL is below -0.99 LSB. With FRAC_W=8, this means `rec_dnl` <= -254.
- R6: A bin holding 2^CNT_W-1 keeps that value when it is incremented. An increment that is lost in this way sets `sat_flag`, which stays high until the next clear command.
- R7: A clear command given while idle zeroes every bin and drops `sat_flag`. Reset starts the same clear. The block takes 2^B cycles to clear and then returns to idle.
- R8: A valid sample that arrives while the block is clearing or computing leaves every bin unchanged and adds one to `dropped_cnt`, which saturates and is reset only by `rst`.
- R9: If every bin from 1 to 2^B-2 is zero, a compute emits no record and raises `done` together with `err_empty` for one cycle.
- R10: After a compute that emits records, `done` pulses for one cycle, in the cycle directly after the last record, with `err_empty` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also starts a clear sweep |
| smp_valid | input | 1 | Converter sample strobe |
| smp_code | input | CODE_W | Converter output code |
| clr_req | input | 1 | Clear all bins (acted on when idle; takes priority over compute) |
| calc_req | input | 1 | Start the DNL/INL computation (acted on when idle) |
| rec_valid | output | 1 | Record strobe |
| rec_code | output | CODE_W | Code of the record |
| rec_count | output | CNT_W | Occurrence count of that code |
| rec_dnl | output | CODE_W+FRAC_W+2 | Signed DNL, FRAC_W fractional bits |
| rec_inl | output | CODE_W+FRAC_W+2 | Signed INL, FRAC_W fractional bits |
| rec_missing | output | 1 | Missing-code flag |
| done | output | 1 | End of computation pulse |
| err_empty | output | 1 | Pulses with done when no retained bin holds a sample |
| sat_flag | output | 1 | Sticky bin saturation flag |
| dropped_cnt | output | DROP_W | Count of discarded samples |

## Verification
The checks assume that `smp_code` is always a defined value and that commands are held for one cycle only. They also assume that reset lasts long enough for the clear sweep that follows it to start from a known state. The divider's exactness check relies on a nonzero denominator, which the empty-histogram test in the control path guarantees. The stimulus drives all inputs on the falling edge and keeps bin counts small, so that saturation can be reached on purpose. Samples are sent into the clear and compute windows only in known numbers, so the bench can predict both the dropped count and the unchanged histogram.

// File: rtl/hla_pkg.sv
package hla_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_SUM,
    ST_CHECK,
    ST_DLOAD,
    ST_DWAIT,
    ST_FINISH
  } hla_state_e;
endpackage

// File: rtl/hla_bin_mem.sv
module hla_bin_mem #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_clr,
  input  logic [CODE_W-1:0] clr_addr,
  input  logic              inc_en,
  input  logic [CODE_W-1:0] inc_addr,
  input  logic [CODE_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              inc_lost
);
  localparam int DEPTH = 1 << CODE_W;

  logic [CNT_W-1:0] mem [DEPTH];
  logic             bin_full;

  assign bin_full = (mem[inc_addr] == {CNT_W{1'b1}});
  assign inc_lost = inc_en && bin_full;
  assign rd_data  = mem[rd_addr];

  // Distributed-RAM style: one write port, asynchronous reads.
  always_ff @(posedge clk) begin
    if (wr_clr)
      mem[clr_addr] <= '0;
    else if (inc_en && !bin_full)
      mem[inc_addr] <= mem[inc_addr] + 1'b1;
  end

  // R6: a full bin stays full when incremented again
  p_sat_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (inc_en && !wr_clr && mem[inc_addr] == {CNT_W{1'b1}})
      |=> (mem[$past(inc_addr)] == {CNT_W{1'b1}}));

  // R7: a clear write leaves the addressed bin at zero
  p_clr_zero_r7: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> (mem[$past(clr_addr)] == '0));
endmodule

// File: rtl/hla_rdiv.sv
module hla_rdiv #(
  parameter int N_W = 28,
  parameter int D_W = 20,
  parameter int Q_W = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N_W-1:0] num,
  input  logic [D_W-1:0] den,
  output logic           done,
  output logic [Q_W-1:0] quo
);
  localparam int S_W = $clog2(N_W + 1);
  localparam int P_W = N_W + D_W + 1;

  logic [N_W-1:0] q_r;
  logic [N_W-1:0] n_keep;
  logic [D_W:0]   r_r;
  logic [D_W-1:0] d_r;
  logic [S_W-1:0] steps;
  logic           busy;
  logic [D_W+1:0] trial;
  logic           ge;

  assign trial = {r_r, q_r[N_W-1]};
  assign ge    = (trial >= (D_W+2)'(d_r));
  assign quo   = q_r[Q_W-1:0];

  // Restoring division: one quotient bit per cycle, MSB first.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_r    <= '0;
      n_keep <= '0;
      r_r    <= '0;
      d_r    <= '0;
      steps  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q_r    <= num;
        n_keep <= num;
        d_r    <= den;
        r_r    <= '0;
        steps  <= S_W'(N_W);
        busy   <= 1'b1;
      end else if (busy) begin
        r_r   <= ge ? (trial[D_W:0] - (D_W+1)'(d_r)) : trial[D_W:0];
        q_r   <= {q_r[N_W-2:0], ge};
        steps <= steps - 1'b1;
        if (steps == S_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R3: the result is exact: quotient * divisor + remainder == dividend
  p_div_exact_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (P_W'(q_r) * P_W'(d_r) + P_W'(r_r) == P_W'(n_keep)));

  // R3: the remainder is below the divisor (floor division)
  p_div_rem_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (r_r < (D_W+1)'(d_r)));
endmodule

// File: rtl/adc_lin_histo.sv
module adc_lin_histo #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8,
  parameter int DROP_W = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             smp_valid,
  input  logic [CODE_W-1:0]                smp_code,
  input  logic                             clr_req,
  input  logic                             calc_req,
  output logic                             rec_valid,
  output logic [CODE_W-1:0]                rec_code,
  output logic [CNT_W-1:0]                 rec_count,
  output logic signed [CODE_W+FRAC_W+1:0]  rec_dnl,
  output logic signed [CODE_W+FRAC_W+1:0]  rec_inl,
  output logic                             rec_missing,
  output logic                             done,
  output logic                             err_empty,
  output logic                             sat_flag,
  output logic [DROP_W-1:0]                dropped_cnt
);
  import hla_pkg::*;

  localparam int NBINS    = 1 << CODE_W;
  localparam int FIRST    = 1;
  localparam int LAST     = NBINS - 2;
  localparam int N_RET    = NBINS - 2;
  localparam int SUM_W    = CNT_W + CODE_W;
  localparam int NUM_W    = SUM_W + FRAC_W;
  localparam int REC_W    = CODE_W + FRAC_W + 2;
  localparam int MISS_MAG = ((99 << FRAC_W) + 99) / 100;
  localparam logic signed [REC_W-1:0] ONE_Q  = REC_W'(1) << FRAC_W;
  localparam logic signed [REC_W-1:0] MISS_Q = -REC_W'(MISS_MAG);

  hla_state_e               st;
  logic [CODE_W-1:0]        idx;
  logic [SUM_W-1:0]         sum_acc;
  logic                     any_nz;
  logic signed [REC_W-1:0]  inl_acc;
  logic [CNT_W-1:0]         cur_cnt;
  logic [CNT_W-1:0]         rd_cnt;
  logic                     inc_lost;
  logic                     div_start;
  logic [NUM_W-1:0]         div_num;
  logic                     div_done;
  logic [REC_W-1:0]         div_quo;
  logic signed [REC_W-1:0]  dnl_c;
  logic                     accept;

  assign accept = smp_valid && (st == ST_IDLE);
  assign dnl_c  = $signed(div_quo) - ONE_Q;

  hla_bin_mem #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_bins (
    .clk      (clk),
    .rst      (rst),
    .wr_clr   (st == ST_CLEAR),
    .clr_addr (idx),
    .inc_en   (accept),
    .inc_addr (smp_code),
    .rd_addr  (idx),
    .rd_data  (rd_cnt),
    .inc_lost (inc_lost)
  );

  hla_rdiv #(.N_W(NUM_W), .D_W(SUM_W), .Q_W(REC_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .num   (div_num),
    .den   (sum_acc),
    .done  (div_done),
    .quo   (div_quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_CLEAR;
      idx         <= '0;
      sum_acc     <= '0;
      any_nz      <= 1'b0;
      inl_acc     <= '0;
      cur_cnt     <= '0;
      div_start   <= 1'b0;
      div_num     <= '0;
      rec_valid   <= 1'b0;
      rec_code    <= '0;
      rec_count   <= '0;
      rec_dnl     <= '0;
      rec_inl     <= '0;
      rec_missing <= 1'b0;
      done        <= 1'b0;
      err_empty   <= 1'b0;
      sat_flag    <= 1'b0;
      dropped_cnt <= '0;
    end else begin
      rec_valid <= 1'b0;
      done      <= 1'b0;
      err_empty <= 1'b0;
      div_start <= 1'b0;
      if (smp_valid && st != ST_IDLE && dropped_cnt != {DROP_W{1'b1}})
        dropped_cnt <= dropped_cnt + 1'b1;
      if (inc_lost)
        sat_flag <= 1'b1;
      case (st)
        ST_CLEAR: begin
          idx <= idx + 1'b1;
          if (idx == CODE_W'(NBINS - 1))
            st <= ST_IDLE;
        end
        ST_IDLE: begin
          if (clr_req) begin
            st       <= ST_CLEAR;
            idx      <= '0;
            sat_flag <= 1'b0;
          end else if (calc_req) begin
            st      <= ST_SUM;
            idx     <= CODE_W'(FIRST);
            sum_acc <= '0;
            any_nz  <= 1'b0;
          end
        end
        ST_SUM: begin
          sum_acc <= sum_acc + SUM_W'(rd_cnt);
          if (rd_cnt != '0)
            any_nz <= 1'b1;
          if (idx == CODE_W'(LAST))
            st <= ST_CHECK;
          else
            idx <= idx + 1'b1;
        end
        ST_CHECK: begin
          if (!any_nz) begin
            done      <= 1'b1;
            err_empty <= 1'b1;
            st        <= ST_IDLE;
          end else begin
            idx     <= CODE_W'(FIRST);
            inl_acc <= '0;
            st      <= ST_DLOAD;
          end
        end
        ST_DLOAD: begin
          cur_cnt   <= rd_cnt;
          div_num   <= (NUM_W'(rd_cnt) * NUM_W'(N_RET)) << FRAC_W;
          div_start <= 1'b1;
          st        <= ST_DWAIT;
        end
        ST_DWAIT: begin
          if (div_done) begin
            rec_valid   <= 1'b1;
            rec_code    <= idx;
            rec_count   <= cur_cnt;
            rec_dnl     <= dnl_c;
            rec_inl     <= inl_acc + dnl_c;
            rec_missing <= (dnl_c <= MISS_Q);
            inl_acc     <= inl_acc + dnl_c;
            if (idx == CODE_W'(LAST)) begin
              st <= ST_FINISH;
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_DLOAD;
            end
          end
        end
        ST_FINISH: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: records never carry an over-range code
  p_endbin_r2: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_code != '0 && rec_code != {CODE_W{1'b1}}));

  // R5: an empty bin always reports as missing
  p_miss_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_count == '0) |-> rec_missing);

  // R6: saturation flag is sticky until a clear is accepted
  p_sat_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (sat_flag && !(st == ST_IDLE && clr_req)) |=> sat_flag);

  // R8: samples during clear or compute are counted as dropped
  p_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && st != ST_IDLE && dropped_cnt != {DROP_W{1'b1}})
      |=> (dropped_cnt == $past(dropped_cnt) + 1'b1));

  // R9: the empty error comes with done and without a record
  p_err_norec_r9: assert property (@(posedge clk) disable iff (rst)
    err_empty |-> (done && !rec_valid));

  // R10: a successful done directly follows the last record
  p_done_after_rec_r10: assert property (@(posedge clk) disable iff (rst)
    (done && !err_empty) |-> $past(rec_valid));
endmodule

// File: tb/adc_lin_histo_bench.sv
module adc_lin_histo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int KW = 8;
  localparam int FW = 8;
  localparam int DW = 16;
  localparam int NB = 1 << CW;
  localparam int NR = NB - 2;
  localparam int RW = CW + FW + 2;
  localparam int KMAX = (1 << KW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [CW-1:0] smp_code = '0;
  logic clr_req = 1'b0;
  logic calc_req = 1'b0;
  logic rec_valid;
  logic [CW-1:0] rec_code;
  logic [KW-1:0] rec_count;
  logic signed [RW-1:0] rec_dnl;
  logic signed [RW-1:0] rec_inl;
  logic rec_missing, done, err_empty, sat_flag;
  logic [DW-1:0] dropped_cnt;

  adc_lin_histo #(.CODE_W(CW), .CNT_W(KW), .FRAC_W(FW), .DROP_W(DW)) u_adc_lin_histo (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_code(smp_code),
    .clr_req(clr_req), .calc_req(calc_req), .rec_valid(rec_valid),
    .rec_code(rec_code), .rec_count(rec_count), .rec_dnl(rec_dnl),
    .rec_inl(rec_inl), .rec_missing(rec_missing), .done(done),
    .err_empty(err_empty), .sat_flag(sat_flag), .dropped_cnt(dropped_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;
  int exp_cnt [NB];
  int exp_dnl [NB];
  int exp_inl [NB];
  bit exp_miss [NB];
  int drop_exp = 0;
  int rec_seen = 0;
  int next_code = 1;
  int last_rec_cyc = -10;
  bit done_seen = 1'b0;
  bit done_err = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Record and done monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst && rec_valid) begin
      chk(rec_code == CW'(next_code), "R2 record code order", rec_code, next_code);
      if (next_code >= 1 && next_code <= NR) begin
        chk(int'(rec_count) == exp_cnt[next_code], "R1 bin count", rec_count, exp_cnt[next_code]);
        chk(int'(rec_dnl) == exp_dnl[next_code], "R3 dnl", rec_dnl, exp_dnl[next_code]);
        chk(int'(rec_inl) == exp_inl[next_code], "R4 inl", rec_inl, exp_inl[next_code]);
        chk(rec_missing == exp_miss[next_code], "R5 missing flag", rec_missing, exp_miss[next_code]);
      end
      next_code++;
      rec_seen++;
      last_rec_cyc = cyc;
    end
    if (!rst && done) begin
      done_seen = 1'b1;
      done_err = err_empty;
      if (rec_seen > 0)
        chk(last_rec_cyc == cyc - 1, "R10 done follows last record", cyc - last_rec_cyc, 1);
    end
  end

  function automatic int sat_inc(input int v);
    return (v >= KMAX) ? KMAX : v + 1;
  endfunction

  task automatic put(input int code);
    smp_valid = 1'b1;
    smp_code = CW'(code);
    exp_cnt[code] = sat_inc(exp_cnt[code]);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic put_drop(input int code);
    smp_valid = 1'b1;
    smp_code = CW'(code);
    drop_exp++;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    smp_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear(input int n_drop);
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    for (int i = 0; i < n_drop; i++) put_drop(i + 2);
    idle(NB + 4);
    for (int c = 0; c < NB; c++) exp_cnt[c] = 0;
  endtask

  // Computes the expected records; returns the number of records
  function automatic int build_expect();
    int sum = 0;
    int acc = 0;
    bit nz = 1'b0;
    for (int c = 1; c <= NR; c++) begin
      sum += exp_cnt[c];
      if (exp_cnt[c] != 0) nz = 1'b1;
    end
    if (!nz) return 0;
    for (int c = 1; c <= NR; c++) begin
      exp_dnl[c] = (exp_cnt[c] * NR * (1 << FW)) / sum - (1 << FW);
      acc += exp_dnl[c];
      exp_inl[c] = acc;
      exp_miss[c] = (exp_dnl[c] <= -254);
    end
    return NR;
  endfunction

  task automatic run_calc(input int n_drop, input string tag);
    int nrec;
    int waited;
    nrec = build_expect();
    rec_seen = 0;
    next_code = 1;
    done_seen = 1'b0;
    calc_req = 1'b1;
    @(negedge clk);
    calc_req = 1'b0;
    for (int i = 0; i < n_drop; i++) put_drop(i);
    waited = 0;
    while (!done_seen && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    chk(done_seen, {tag, " done seen"}, done_seen, 1);
    chk(rec_seen == nrec, {tag, " record total"}, rec_seen, nrec);
    chk(done_err == (nrec == 0), {tag, " err_empty"}, done_err, nrec == 0);
    idle(2);
  endtask

  initial begin
    int n;
    void'($urandom(32'd5821));
    for (int c = 0; c < NB; c++) exp_cnt[c] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(NB + 4);
    // reset state (R7 clear after reset)
    chk(rec_valid == 1'b0, "R7 reset rec_valid", rec_valid, 0);
    chk(done == 1'b0, "R7 reset done", done, 0);
    chk(sat_flag == 1'b0, "R6 reset sat_flag", sat_flag, 0);
    chk(dropped_cnt == '0, "R8 reset dropped", dropped_cnt, 0);

    // R9: compute on an empty histogram
    run_calc(0, "R9 empty");

    // R1 R3 R4: ramp with uneven counts per code, end bins included
    for (int c = 0; c < NB; c++) begin
      n = 20 + int'($urandom % 15);
      for (int k = 0; k < n; k++) put(c);
    end
    idle(2);
    run_calc(0, "R1 ramp");

    // R8: samples during compute are dropped and leave bins intact
    run_calc(4, "R8 compute drop");
    chk(int'(dropped_cnt) == drop_exp, "R8 dropped count", dropped_cnt, drop_exp);
    run_calc(0, "R8 bins unchanged");

    // R5 R7: clear with dropped samples, then missing codes at the threshold
    do_clear(3);
    chk(int'(dropped_cnt) == drop_exp, "R8 dropped in clear", dropped_cnt, drop_exp);
    for (int c = 0; c < NB; c++) begin
      if (c == 5) continue;
      if (c == 9) begin
        put(c);
        continue;
      end
      for (int k = 0; k < 100; k++) put(c);
    end
    idle(2);
    run_calc(0, "R5 missing");

    // R6: saturation boundary
    do_clear(0);
    for (int k = 0; k < KMAX; k++) put(3);
    idle(2);
    chk(sat_flag == 1'b0, "R6 flag low at full", sat_flag, 0);
    put(3);
    idle(2);
    chk(sat_flag == 1'b1, "R6 flag set on lost increment", sat_flag, 1);
    for (int k = 0; k < 5; k++) put(3);
    for (int c = 1; c < NB - 1; c++) put(c);
    idle(2);
    run_calc(0, "R6 saturated bin");
    chk(sat_flag == 1'b1, "R6 flag sticky", sat_flag, 1);

    // R7: clear drops the flag and empties every bin
    do_clear(0);
    chk(sat_flag == 1'b0, "R7 clear drops sat_flag", sat_flag, 0);
    run_calc(0, "R7 bins zeroed");

    // R2 R9: only over-range codes present
    for (int k = 0; k < 30; k++) begin
      put(0);
      put(NB - 1);
    end
    idle(2);
    run_calc(0, "R2 end bins only");

    // Random codes, back to back
    for (int k = 0; k < 400; k++) put(int'($urandom % NB));
    idle(2);
    run_calc(0, "R3 random");

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule